// File: doc/BRIEF.md
# External Bus Access Timing Sequencer

This block turns system read and write requests into timed cycles on an external parallel bus. It serves several chip-select regions, and each region has its own timing word. All timing is counted in cycles of the functional clock. The word sets the access length, the assert and deassert cycle of each strobe (chip-select, address-valid, output-enable, write-enable), the cycle at which read data is captured, the cycle at which the external wait pin is monitored, and the idle gap that must follow an access before a different region may be selected.

When a request is accepted, the block latches the selected timing word and starts a cycle counter at zero. Each strobe is a window over the counter value. The counter freezes while the wait pin is high at the monitor cycle. The address and data can share one bus. A burst is handled in one of two ways. If the device supports bursts and the direction is configured as synchronous, the burst is run as a native burst in which later beats skip the address phase. Otherwise it is broken into full single accesses. Devices flagged as 8 bits wide always get single accesses.

The requester presents one request at a time and sees one `beat_done` pulse per beat. It changes `wdata` after each pulse and collects read data on `rd_valid`.

Top module: `extbus_seq`

## Requirements
- R1: Each region's timing word occupies `cfg_flat[i*77 +: 77]`. From MSB to LSB it holds twelve 6-bit counts: cycle time T, idle gap, cs on, cs off, adv on, adv off, oe on, oe off, we on, we off, capture cycle, wait cycle. Five flag bits follow: mux, burst-capable, 8-bit device, read-synchronous, write-synchronous. The word is latched when a request is accepted, and later changes do not affect the running access.
- R2: `req_ready` is high only when no access is running. A request accepted at a clock edge starts its access in the next cycle, with the counter at 0.
- R3: With counter value c, a strobe is high when on <= c < off. Only the selected region's `bus_cs_act` bit can be high. `bus_oe` is high only for reads and `bus_we` only for writes.
- R4: Each beat takes T counter values, 0 to T-1 from its start point. `beat_done` is high in the last cycle of each beat, and the access ends after the last beat (`req_len`+1 beats).
- R5: For reads, `rd_valid` is high in the cycle where c equals the capture cycle and no stall is in effect. In that cycle `rd_data` equals `bus_din`.
- R6: When c equals the wait cycle and `wait_in` is high, the counter and all outputs hold. Counting resumes at the edge that ends the first such cycle with `wait_in` low.
- R7: With mux set, `bus_dout` carries the address (zero-extended) with `bus_drv_en` high while c < adv off, and `bus_addr` is 0. After that phase it carries `wdata` for writes and is not driven for reads. With mux clear, `bus_addr` holds the beat address, and `bus_dout` = `wdata` is driven only for writes.
- R8: A native burst (burst-capable set, 8-bit clear, and the direction's synchronous flag set) starts each later beat at c = adv off. The beat address increases by 1 per beat.
- R9: Any other burst restarts each beat at c = 0 as a full single access, with the address increasing by 1 per beat and no idle cycle between beats.
- R10: The 8-bit flag forces single accesses even when burst-capable is set.
- R11: After an access on region A with idle gap N, a request for a different region is not ready until N+1 idle cycles have passed. A request for region A is ready in the first idle cycle.
- R12: In reset and right after it, all strobes, `bus_drv_en`, `rd_valid` and `beat_done` are low and `req_ready` is high.
- R13: Reads use the read-synchronous flag and writes the write-synchronous flag, each on its own, when the burst style is chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_flat | input | NUM_CS*77 | Per-region timing words |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | CS_W | Target region |
| req_addr | input | ADDR_W | Start address |
| req_len | input | LEN_W | Beats minus one |
| wdata | input | DATA_W | Write data of the current beat |
| beat_done | output | 1 | Last cycle of a beat |
| rd_valid | output | 1 | Read data captured this cycle |
| rd_data | output | DATA_W | Captured read data |
| wait_in | input | 1 | External wait pin, active high |
| bus_cs_act | output | NUM_CS | Chip-select per region, active high |
| bus_adv | output | 1 | Address-valid strobe |
| bus_oe | output | 1 | Output-enable strobe |
| bus_we | output | 1 | Write-enable strobe |
| bus_addr | output | ADDR_W | Address bus (0 in mux mode) |
| bus_dout | output | DATA_W | Outgoing value on the data bus |
| bus_drv_en | output | 1 | Drive enable for the data bus |
| bus_din | input | DATA_W | Incoming value on the data bus |

## Verification
Random timing words with random strobe windows, capture points and wait points are run against reads and writes of random length. A cycle-by-cycle expectation of the counter catches any error in window edges or beat length. Directed cases follow:
- A native read burst is followed by a write burst on the same region with the write-synchronous flag clear. This separates the restart point at adv off from the restart point at 0, and shows that the two directions are decoded on their own.
- A burst-capable 8-bit device isolates the width override.
- Wait pulses held for several cycles at the monitor point distinguish a frozen counter from a late one.
- Back-to-back accesses to different regions and to the same region, with a large idle gap, show whether the gap is applied only on a change of region.
- A timing word rewritten during an access shows whether the word is latched.

// File: rtl/extbus_pkg.sv
package extbus_pkg;

  localparam int TW = 6;

  typedef struct packed {
    logic [TW-1:0] cyc_time;
    logic [TW-1:0] idle_gap;
    logic [TW-1:0] cs_on;
    logic [TW-1:0] cs_off;
    logic [TW-1:0] adv_on;
    logic [TW-1:0] adv_off;
    logic [TW-1:0] oe_on;
    logic [TW-1:0] oe_off;
    logic [TW-1:0] we_on;
    logic [TW-1:0] we_off;
    logic [TW-1:0] cap_at;
    logic [TW-1:0] wait_at;
    logic          mux_en;
    logic          burst_ok;
    logic          dev8;
    logic          rd_sync;
    logic          wr_sync;
  } cs_timing_t;

  localparam int CFG_W = $bits(cs_timing_t);

  typedef enum logic {ST_IDLE = 1'b0, ST_ACTIVE = 1'b1} seq_state_t;

  // strobe window: high from the on value up to, not including, the off value
  function automatic logic in_window(input logic [TW-1:0] on_v,
                                     input logic [TW-1:0] off_v,
                                     input logic [TW-1:0] c);
    return (c >= on_v) && (c < off_v);
  endfunction

  // last counter value of a beat; a zero cycle time behaves as one cycle
  function automatic logic beat_is_last(input logic [TW-1:0] c,
                                        input logic [TW-1:0] t);
    return ((TW+1)'(c) + (TW+1)'(1)) >= (TW+1)'(t);
  endfunction

  // counter value at which a follow-on beat begins
  function automatic logic [TW-1:0] restart_point(input logic native,
                                                  input logic [TW-1:0] adv_off,
                                                  input logic [TW-1:0] t);
    return (native && (adv_off < t)) ? adv_off : '0;
  endfunction

  function automatic logic native_burst(input cs_timing_t cfg, input logic wr);
    return cfg.burst_ok && !cfg.dev8 && (wr ? cfg.wr_sync : cfg.rd_sync);
  endfunction

endpackage

// File: rtl/extbus_cfg_sel.sv
module extbus_cfg_sel
  import extbus_pkg::*;
#(
  parameter int NUM_CS = 4,
  localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic [NUM_CS*CFG_W-1:0] cfg_flat,
  input  logic [CS_W-1:0]         sel,
  output cs_timing_t              cfg
);

  cs_timing_t words [NUM_CS];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_unpack
    assign words[g] = cs_timing_t'(cfg_flat[g*CFG_W +: CFG_W]);
  end

  always_comb begin
    cfg = words[0];
    for (int i = 0; i < NUM_CS; i++) begin
      if (sel == CS_W'(i)) cfg = words[i];
    end
  end

endmodule

// File: rtl/extbus_seq_ctrl.sv
module extbus_seq_ctrl
  import extbus_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 4,
  localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [CS_W-1:0]   req_cs,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  cs_timing_t        sel_cfg,
  input  logic              wait_in,
  output logic              req_ready,
  output logic              active,
  output logic [TW-1:0]     cnt,
  output logic              stall,
  output logic              beat_done,
  output logic [CS_W-1:0]   cur_cs,
  output logic              cur_wr,
  output logic [ADDR_W-1:0] cur_addr,
  output cs_timing_t        cur_cfg
);

  seq_state_t       state;
  logic [LEN_W-1:0] beats_left;
  logic             cur_native;
  logic [TW-1:0]    gap_cnt;
  logic [CS_W-1:0]  last_cs;
  logic             has_last;

  logic accept;
  logic last_val;
  logic advance;
  logic acc_end;

  assign active    = (state == ST_ACTIVE);
  assign last_val  = beat_is_last(cnt, cur_cfg.cyc_time);
  assign stall     = active && (cnt == cur_cfg.wait_at) && wait_in;
  assign advance   = active && !stall;
  assign beat_done = advance && last_val;
  assign acc_end   = beat_done && (beats_left == '0);

  assign req_ready = !active && (!has_last || (req_cs == last_cs) || (gap_cnt == '0));
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      beats_left <= '0;
      cur_native <= 1'b0;
      cur_cs     <= '0;
      cur_wr     <= 1'b0;
      cur_addr   <= '0;
      cur_cfg    <= '0;
      gap_cnt    <= '0;
      last_cs    <= '0;
      has_last   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (gap_cnt != '0) gap_cnt <= gap_cnt - 1'b1;
          if (accept) begin
            state      <= ST_ACTIVE;
            cnt        <= '0;
            beats_left <= req_len;
            cur_cs     <= req_cs;
            cur_wr     <= req_write;
            cur_addr   <= req_addr;
            cur_cfg    <= sel_cfg;
            cur_native <= native_burst(sel_cfg, req_write);
          end
        end
        ST_ACTIVE: begin
          if (acc_end) begin
            state    <= ST_IDLE;
            gap_cnt  <= cur_cfg.idle_gap;
            last_cs  <= cur_cs;
            has_last <= 1'b1;
          end else if (beat_done) begin
            beats_left <= beats_left - 1'b1;
            cur_addr   <= cur_addr + 1'b1;
            cnt        <= restart_point(cur_native, cur_cfg.adv_off, cur_cfg.cyc_time);
          end else if (advance) begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/extbus_strobe_gen.sv
module extbus_strobe_gen
  import extbus_pkg::*;
#(
  parameter int NUM_CS = 4,
  localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              active,
  input  logic              stall,
  input  logic [TW-1:0]     cnt,
  input  logic              cur_wr,
  input  logic [CS_W-1:0]   cur_cs,
  input  logic [TW-1:0]     cs_on,
  input  logic [TW-1:0]     cs_off,
  input  logic [TW-1:0]     adv_on,
  input  logic [TW-1:0]     adv_off,
  input  logic [TW-1:0]     oe_on,
  input  logic [TW-1:0]     oe_off,
  input  logic [TW-1:0]     we_on,
  input  logic [TW-1:0]     we_off,
  input  logic [TW-1:0]     cap_at,
  output logic [NUM_CS-1:0] bus_cs_act,
  output logic              bus_adv,
  output logic              bus_oe,
  output logic              bus_we,
  output logic              rd_valid
);

  logic cs_win;

  assign cs_win = active && in_window(cs_on, cs_off, cnt);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign bus_cs_act[g] = cs_win && (cur_cs == CS_W'(g));
  end

  assign bus_adv  = active && in_window(adv_on, adv_off, cnt);
  assign bus_oe   = active && !cur_wr && in_window(oe_on, oe_off, cnt);
  assign bus_we   = active &&  cur_wr && in_window(we_on, we_off, cnt);
  assign rd_valid = active && !cur_wr && !stall && (cnt == cap_at);

endmodule

// File: rtl/extbus_bus_mux.sv
module extbus_bus_mux
  import extbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              active,
  input  logic [TW-1:0]     cnt,
  input  logic              mux_en,
  input  logic [TW-1:0]     adv_off,
  input  logic              cur_wr,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] bus_din,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_drv_en,
  output logic [DATA_W-1:0] rd_data
);

  logic addr_phase;

  assign addr_phase = mux_en && (cnt < adv_off);
  assign bus_addr   = mux_en ? '0 : cur_addr;
  assign bus_dout   = addr_phase ? DATA_W'(cur_addr) : wdata;
  assign bus_drv_en = active && (cur_wr || addr_phase);
  assign rd_data    = bus_din;

endmodule

// File: rtl/extbus_seq.sv
module extbus_seq
  import extbus_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LEN_W  = 4,
  localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CS*CFG_W-1:0] cfg_flat,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [CS_W-1:0]         req_cs,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [LEN_W-1:0]        req_len,
  input  logic [DATA_W-1:0]       wdata,
  output logic                    beat_done,
  output logic                    rd_valid,
  output logic [DATA_W-1:0]       rd_data,
  input  logic                    wait_in,
  output logic [NUM_CS-1:0]       bus_cs_act,
  output logic                    bus_adv,
  output logic                    bus_oe,
  output logic                    bus_we,
  output logic [ADDR_W-1:0]       bus_addr,
  output logic [DATA_W-1:0]       bus_dout,
  output logic                    bus_drv_en,
  input  logic [DATA_W-1:0]       bus_din
);

  cs_timing_t        sel_cfg;
  cs_timing_t        cur_cfg;
  logic              active;
  logic              stall;
  logic [TW-1:0]     cnt;
  logic [CS_W-1:0]   cur_cs;
  logic              cur_wr;
  logic [ADDR_W-1:0] cur_addr;

  extbus_cfg_sel #(.NUM_CS(NUM_CS)) cfg_sel_i (
    .cfg_flat (cfg_flat),
    .sel      (req_cs),
    .cfg      (sel_cfg)
  );

  extbus_seq_ctrl #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_cs    (req_cs),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .sel_cfg   (sel_cfg),
    .wait_in   (wait_in),
    .req_ready (req_ready),
    .active    (active),
    .cnt       (cnt),
    .stall     (stall),
    .beat_done (beat_done),
    .cur_cs    (cur_cs),
    .cur_wr    (cur_wr),
    .cur_addr  (cur_addr),
    .cur_cfg   (cur_cfg)
  );

  extbus_strobe_gen #(.NUM_CS(NUM_CS)) strobe_i (
    .active     (active),
    .stall      (stall),
    .cnt        (cnt),
    .cur_wr     (cur_wr),
    .cur_cs     (cur_cs),
    .cs_on      (cur_cfg.cs_on),
    .cs_off     (cur_cfg.cs_off),
    .adv_on     (cur_cfg.adv_on),
    .adv_off    (cur_cfg.adv_off),
    .oe_on      (cur_cfg.oe_on),
    .oe_off     (cur_cfg.oe_off),
    .we_on      (cur_cfg.we_on),
    .we_off     (cur_cfg.we_off),
    .cap_at     (cur_cfg.cap_at),
    .bus_cs_act (bus_cs_act),
    .bus_adv    (bus_adv),
    .bus_oe     (bus_oe),
    .bus_we     (bus_we),
    .rd_valid   (rd_valid)
  );

  extbus_bus_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) bus_i (
    .active     (active),
    .cnt        (cnt),
    .mux_en     (cur_cfg.mux_en),
    .adv_off    (cur_cfg.adv_off),
    .cur_wr     (cur_wr),
    .cur_addr   (cur_addr),
    .wdata      (wdata),
    .bus_din    (bus_din),
    .bus_addr   (bus_addr),
    .bus_dout   (bus_dout),
    .bus_drv_en (bus_drv_en),
    .rd_data    (rd_data)
  );

endmodule

// File: rtl/extbus_seq_chk.sv
module extbus_seq_chk
  import extbus_pkg::*;
#(
  parameter int NUM_CS = 4,
  localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CS-1:0] bus_cs_act,
  input logic              bus_oe,
  input logic              bus_we,
  input logic              rd_valid,
  input logic              req_ready,
  input logic              active,
  input logic              stall,
  input logic [TW-1:0]     cnt,
  input logic              cur_wr,
  input logic [CS_W-1:0]   cur_cs,
  input logic [TW-1:0]     cur_idle
);

  logic            active_q;
  logic            have_prev;
  logic [CS_W-1:0] prev_cs;
  logic [TW-1:0]   prev_idle;
  logic [TW:0]     quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      have_prev <= 1'b0;
      prev_cs   <= '0;
      prev_idle <= '0;
      quiet     <= '0;
    end else begin
      active_q <= active;
      if (active) begin
        prev_cs   <= cur_cs;
        prev_idle <= cur_idle;
        have_prev <= 1'b1;
        quiet     <= '0;
      end else if (quiet != '1) begin
        quiet <= quiet + 1'b1;
      end
    end
  end

  // R3: at most one region selected
  a_r3_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_cs_act));

  // R3: read and write strobes never together
  a_r3_oe_we_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_oe && bus_we));

  // R6: a stall freezes the counter
  a_r6_stall_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (active && $stable(cnt)));

  // R5: capture only on reads
  a_r5_capture_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (active && !cur_wr));

  // R2: no acceptance while an access runs
  a_r2_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !active);

  // R11: idle gap honoured on a change of region
  a_r11_idle_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !active_q && have_prev && (cur_cs != prev_cs))
      |-> (quiet >= ((TW+1)'(prev_idle) + (TW+1)'(1))));

endmodule

bind extbus_seq extbus_seq_chk #(.NUM_CS(NUM_CS)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_cs_act (bus_cs_act),
  .bus_oe     (bus_oe),
  .bus_we     (bus_we),
  .rd_valid   (rd_valid),
  .req_ready  (req_ready),
  .active     (active),
  .stall      (stall),
  .cnt        (cnt),
  .cur_wr     (cur_wr),
  .cur_cs     (cur_cs),
  .cur_idle   (cur_cfg.idle_gap)
);

// File: tb/extbus_seq_tb.sv
module extbus_seq_tb_top;
  import extbus_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_CS = 4;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int LEN_W  = 4;
  localparam int CS_W   = 2;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic [NUM_CS*CFG_W-1:0] cfg_flat = '0;
  logic                    req_valid = 1'b0;
  logic                    req_ready;
  logic                    req_write = 1'b0;
  logic [CS_W-1:0]         req_cs = '0;
  logic [ADDR_W-1:0]       req_addr = '0;
  logic [LEN_W-1:0]        req_len = '0;
  logic [DATA_W-1:0]       wdata = '0;
  logic                    beat_done;
  logic                    rd_valid;
  logic [DATA_W-1:0]       rd_data;
  logic                    wait_in = 1'b0;
  logic [NUM_CS-1:0]       bus_cs_act;
  logic                    bus_adv;
  logic                    bus_oe;
  logic                    bus_we;
  logic [ADDR_W-1:0]       bus_addr;
  logic [DATA_W-1:0]       bus_dout;
  logic                    bus_drv_en;
  logic [DATA_W-1:0]       bus_din = '0;

  int checks = 0;
  int errors = 0;

  cs_timing_t tcfg [NUM_CS];
  int  q = 0;
  bit  have_prev = 1'b0;
  int  prev_cs = 0;
  int  prev_idle = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  extbus_seq #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_flat(cfg_flat),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_cs(req_cs), .req_addr(req_addr), .req_len(req_len), .wdata(wdata),
    .beat_done(beat_done), .rd_valid(rd_valid), .rd_data(rd_data),
    .wait_in(wait_in), .bus_cs_act(bus_cs_act), .bus_adv(bus_adv),
    .bus_oe(bus_oe), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_drv_en(bus_drv_en), .bus_din(bus_din)
  );

  task automatic check(input bit ok, input string what, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", what, got, exp);
    end
  endtask

  function automatic cs_timing_t rand_cfg();
    cs_timing_t c;
    int t;
    int on;
    c = '0;
    t = 3 + int'($urandom % 10);
    c.cyc_time = TW'(t);
    c.idle_gap = TW'($urandom % 5);
    on = int'($urandom % t);  c.cs_on = TW'(on);  c.cs_off = TW'(on + 1 + int'($urandom % (t - on)));
    on = int'($urandom % (t - 1)); c.adv_on = TW'(on); c.adv_off = TW'(on + 1 + int'($urandom % (t - 1 - on)));
    on = int'($urandom % t);  c.oe_on = TW'(on);  c.oe_off = TW'(on + 1 + int'($urandom % (t - on)));
    on = int'($urandom % t);  c.we_on = TW'(on);  c.we_off = TW'(on + 1 + int'($urandom % (t - on)));
    c.cap_at  = TW'($urandom % t);
    c.wait_at = TW'($urandom % t);
    c.mux_en   = 1'($urandom);
    c.burst_ok = 1'($urandom);
    c.dev8     = 1'($urandom);
    c.rd_sync  = 1'($urandom);
    c.wr_sync  = 1'($urandom);
    return c;
  endfunction

  task automatic apply_cfg();
    for (int i = 0; i < NUM_CS; i++) cfg_flat[i*CFG_W +: CFG_W] = tcfg[i];
  endtask

  function automatic bit exp_native(input cs_timing_t c, input bit wr);
    return c.burst_ok && !c.dev8 && (wr ? c.wr_sync : c.rd_sync);
  endfunction

  function automatic bit exp_win(input int on, input int off, input int c);
    return (c >= on) && (c < off);
  endfunction

  task automatic tick();
    @(negedge clk);
    q++;
  endtask

  task automatic do_access(input int cs, input bit wr, input logic [ADDR_W-1:0] addr,
                           input int len, input int max_stall, input bit scramble,
                           input string tag);
    cs_timing_t c;
    int cc;
    int beat;
    int stalls;
    int guard;
    bit stall_now;
    bit exp_rdy;
    bit native;
    logic [ADDR_W-1:0] baddr;
    logic [NUM_CS-1:0] e_cs;
    logic [3:0] e_str;
    logic [3:0] g_str;
    bit e_drv;
    bit e_rv;
    bit e_done;
    bit aph;
    logic [DATA_W-1:0] e_dout;
    logic [ADDR_W-1:0] e_addr;
    c = tcfg[cs];
    native = exp_native(c, wr);
    guard = 0;
    forever begin
      tick();
      req_cs = CS_W'(cs); req_write = wr; req_addr = addr; req_len = LEN_W'(len);
      #1;
      exp_rdy = !have_prev || (cs == prev_cs) || (q >= prev_idle + 1);
      check(req_ready == exp_rdy, $sformatf("%s R11 R2 ready (idle cycle %0d)", tag, q), 64'(req_ready), 64'(exp_rdy));
      guard++;
      if (req_ready || guard > 40) break;
    end
    req_valid = 1'b1;
    wdata = DATA_W'($urandom);
    cc = 0; beat = 0; baddr = addr;
    stalls = (max_stall > 0) ? int'($urandom % (max_stall + 1)) : 0;
    forever begin
      @(negedge clk);
      req_valid = 1'b0;
      if (scramble && beat == 0 && cc == 0) begin
        tcfg[cs] = rand_cfg();
        apply_cfg();
      end
      bus_din = DATA_W'($urandom);
      stall_now = (cc == int'(c.wait_at)) && (stalls > 0);
      wait_in = stall_now;
      if (stall_now) stalls--;
      #1;
      e_cs   = exp_win(c.cs_on, c.cs_off, cc) ? NUM_CS'(1 << cs) : '0;
      e_str  = {exp_win(c.adv_on, c.adv_off, cc),
                !wr && exp_win(c.oe_on, c.oe_off, cc),
                wr && exp_win(c.we_on, c.we_off, cc), 1'b0};
      g_str  = {bus_adv, bus_oe, bus_we, 1'b0};
      check(bus_cs_act == e_cs && g_str == e_str,
            $sformatf("%s R3 R1 strobes c=%0d", tag, cc), 64'({bus_cs_act, g_str}), 64'({e_cs, e_str}));
      aph    = c.mux_en && (cc < int'(c.adv_off));
      e_drv  = wr || aph;
      e_dout = aph ? DATA_W'(baddr) : wdata;
      e_addr = c.mux_en ? '0 : baddr;
      check(bus_drv_en == e_drv && bus_addr == e_addr && (!e_drv || bus_dout == e_dout),
            $sformatf("%s R7 R8 R9 bus c=%0d", tag, cc),
            64'({bus_drv_en, bus_addr, bus_dout}), 64'({e_drv, e_addr, e_dout}));
      e_rv = !wr && (cc == int'(c.cap_at)) && !stall_now;
      check(rd_valid == e_rv && (!e_rv || rd_data == bus_din),
            $sformatf("%s R5 R6 capture c=%0d", tag, cc), 64'({rd_valid, rd_data}), 64'({e_rv, bus_din}));
      e_done = !stall_now && (cc + 1 >= int'(c.cyc_time));
      check(beat_done == e_done, $sformatf("%s R4 R6 beat end c=%0d", tag, cc), 64'(beat_done), 64'(e_done));
      if (!stall_now) begin
        if (e_done) begin
          if (beat == len) break;
          beat++;
          baddr = baddr + 1'b1;
          cc = (native && c.adv_off < c.cyc_time) ? int'(c.adv_off) : 0;
          wdata = DATA_W'($urandom);
          stalls = (max_stall > 0) ? int'($urandom % (max_stall + 1)) : 0;
        end else begin
          cc++;
        end
      end
    end
    wait_in = 1'b0;
    q = 0;
    have_prev = 1'b1;
    prev_cs = cs;
    prev_idle = int'(c.idle_gap);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired: got running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < NUM_CS; i++) tcfg[i] = rand_cfg();
    apply_cfg();
    repeat (3) @(negedge clk);
    #1;
    check(bus_cs_act == '0 && !bus_adv && !bus_oe && !bus_we && !bus_drv_en && !rd_valid && !beat_done,
          "R12 strobes in reset", 64'({bus_cs_act, bus_adv, bus_oe, bus_we}), 64'(0));
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(req_ready == 1'b1 && bus_cs_act == '0 && !beat_done, "R12 ready after reset",
          64'({req_ready, bus_cs_act}), 64'(5'b10000));

    // D1: plain read, non-muxed, with the timing word rewritten mid-access (R1)
    tcfg[0].mux_en = 1'b0;
    apply_cfg();
    do_access(0, 1'b0, 16'h1234, 0, 0, 1'b1, "D1 R1");
    // D2: muxed write
    tcfg[1].mux_en = 1'b1;
    apply_cfg();
    do_access(1, 1'b1, 16'h00a5, 0, 0, 1'b0, "D2 R7");
    // D3: native read burst
    tcfg[2].burst_ok = 1'b1; tcfg[2].dev8 = 1'b0; tcfg[2].rd_sync = 1'b1; tcfg[2].wr_sync = 1'b0;
    apply_cfg();
    do_access(2, 1'b0, 16'h0100, 3, 0, 1'b0, "D3 R8");
    // D4: write on same region, write not synchronous: split
    do_access(2, 1'b1, 16'h0200, 2, 0, 1'b0, "D4 R13 R9");
    // D5: 8-bit device forces single accesses
    tcfg[3].burst_ok = 1'b1; tcfg[3].dev8 = 1'b1; tcfg[3].rd_sync = 1'b1;
    apply_cfg();
    do_access(3, 1'b0, 16'hfffe, 2, 0, 1'b0, "D5 R10");
    // D6: wait stalls on a burst
    tcfg[0].cyc_time = 6'd8; tcfg[0].wait_at = 6'd3; tcfg[0].cap_at = 6'd3;
    tcfg[0].cs_on = 6'd0; tcfg[0].cs_off = 6'd8;
    tcfg[0].adv_on = 6'd0; tcfg[0].adv_off = 6'd2;
    tcfg[0].oe_on = 6'd2; tcfg[0].oe_off = 6'd8; tcfg[0].we_on = 6'd2; tcfg[0].we_off = 6'd7;
    tcfg[0].idle_gap = 6'd2;
    apply_cfg();
    do_access(0, 1'b0, 16'h0040, 2, 4, 1'b0, "D6 R6");
    // D7: large gap, then a change of region, then the same region again
    tcfg[3].idle_gap = 6'd4;
    apply_cfg();
    do_access(3, 1'b1, 16'h0800, 0, 0, 1'b0, "D7a R11");
    do_access(1, 1'b0, 16'h0900, 0, 0, 1'b0, "D7b R11");
    do_access(1, 1'b0, 16'h0901, 0, 0, 1'b0, "D7c R11");

    // random phase
    for (int n = 0; n < 150; n++) begin
      if (n % 25 == 0) begin
        for (int i = 0; i < NUM_CS; i++) tcfg[i] = rand_cfg();
        apply_cfg();
      end
      do_access(int'($urandom % NUM_CS), 1'($urandom), ADDR_W'($urandom),
                int'($urandom % 4), 3, 1'($urandom % 8 == 0), "RND R2 R4");
    end

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule